// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block sits between a serial shift engine and the open-drain clock and data pin drivers of an I2C bus. Both pins are modelled as pull-low enables: a 1 on an enable output means the line is driven low, a 0 means it is released. The block has two modes, chosen by `gen_mode_i`. With the mode at 0, the pins carry the shift engine's clock and data, and software makes start and stop conditions itself by pulling lines low through a separate override path. With the mode at 1, the block produces start, repeated-start and stop conditions in hardware when software asks for them, and ignores the override path.

The block always watches the synchronized bus lines for start and stop conditions and pulses a detect output for each. The shared condition interrupt `cond_irq_o` means different things in each mode. With the mode at 0 it fires when a condition is seen on the bus. With the mode at 1 it fires when a requested condition has been generated. Every generation phase lasts `HOLD_CYC` system clocks.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: With `gen_mode_i`=0, each enable output is the OR of the shift engine's enable and the software override enable for that line, in the same cycle.
- R2: With `gen_mode_i`=0, request pulses have no effect: `req_pend_o` stays 0 and the pins keep following R1.
- R3: With `gen_mode_i`=1 and no generation running, the enables follow the shift engine alone and the software override is ignored.
- R4: `req_pend_o` bit 0 is start, bit 1 is restart and bit 2 is stop. A request pulse sets its bit at the next edge, and generation begins one edge after the bit is set. A start holds SDA low with SCL released for HOLD_CYC cycles, then holds both low for HOLD_CYC cycles, then clears bit 0 and ends.
- R5: A restart releases SDA with SCL low for HOLD_CYC cycles, then releases both for HOLD_CYC cycles, then runs the start sequence of R4, then clears bit 1 and ends.
- R6: A stop holds both low for HOLD_CYC cycles, then releases SCL with SDA low for HOLD_CYC cycles, then releases both for HOLD_CYC cycles, then clears bit 2 and ends.
- R7: When several requests are pending, stop is served before restart, and restart before start. Only the bit just served clears when its sequence ends.
- R8: After two-flop synchronization, SDA falling while SCL is high pulses `start_det_o`, and SDA rising while SCL is high pulses `stop_det_o`. An SDA change while SCL is low pulses neither.
- R9: With `gen_mode_i`=0, `cond_irq_o` pulses on each start or stop detection.
- R10: With `gen_mode_i`=1, `cond_irq_o` pulses in the cycle after a sequence ends, and never because of a condition that another device makes on the bus.
- R11: `start_det_o`, `stop_det_o` and `cond_irq_o` are single-cycle pulses.
- R12: Dropping `gen_mode_i` to 0 in the middle of a sequence stops it at once and clears every pending request at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_mode_i | input | 1 | 1 = hardware condition generation, 0 = software/port conditions |
| shift_scl_oe_i | input | 1 | Shift engine clock pull-low |
| shift_sda_oe_i | input | 1 | Shift engine data pull-low |
| sw_scl_oe_i | input | 1 | Software override clock pull-low (used in mode 0) |
| sw_sda_oe_i | input | 1 | Software override data pull-low (used in mode 0) |
| req_set_i | input | 3 | Request pulses: bit 0 start, bit 1 restart, bit 2 stop |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_oe_o | output | 1 | SCL pull-low enable |
| sda_oe_o | output | 1 | SDA pull-low enable |
| req_pend_o | output | 3 | Pending requests, same bit order as req_set_i |
| start_det_o | output | 1 | Start condition detected pulse |
| stop_det_o | output | 1 | Stop condition detected pulse |
| cond_irq_o | output | 1 | Start/stop interrupt request pulse |

## Verification
Each generation kind is requested on its own. The bench records the pin enables every cycle, groups them into runs, and compares each run with the expected pattern. This shows whether the phases come in the right order and whether each one lasts exactly HOLD_CYC cycles. Requesting all three kinds in the same cycle shows whether the serving order is right and whether only the served bit clears. Bus conditions are made three ways: by the software override in mode 0, by a modelled second device in mode 1, and by SDA toggles while SCL is low. Together these separate detection from the interrupt source, and separate real conditions from plain data changes.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int unsigned REQ_W       = 3;
  localparam int unsigned REQ_START   = 0;
  localparam int unsigned REQ_RESTART = 1;
  localparam int unsigned REQ_STOP    = 2;

  typedef enum logic [2:0] {
    G_IDLE,
    G_RS_SDA_REL,
    G_RS_SCL_REL,
    G_ST_SDA_LO,
    G_ST_SCL_LO,
    G_SP_SDA_LO,
    G_SP_SCL_REL,
    G_SP_SDA_REL
  } gen_state_e;
endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '1;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '1;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_det_o,
  output logic stop_det_o
);
  logic scl_prev_q, sda_prev_q;
  logic scl_steady_hi;

  // SCL must be high on both samples so a simultaneous edge is not taken
  assign scl_steady_hi = scl_s_i & scl_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q  <= 1'b1;
      sda_prev_q  <= 1'b1;
      start_det_o <= 1'b0;
      stop_det_o  <= 1'b0;
    end else begin
      scl_prev_q  <= scl_s_i;
      sda_prev_q  <= sda_s_i;
      start_det_o <= scl_steady_hi & sda_prev_q & ~sda_s_i;
      stop_det_o  <= scl_steady_hi & ~sda_prev_q & sda_s_i;
    end
  end
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [REQ_W-1:0] req_set_i,
  output logic [REQ_W-1:0] pend_o,
  output logic             busy_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  gen_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [REQ_W-1:0] pend_q, clr;
  logic [1:0]       kind_q, kind_d;
  logic             done_q, done_d;
  logic             last;

  assign last = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    clr     = '0;
    done_d  = 1'b0;
    if (state_q == G_IDLE) begin
      cnt_d = '0;
      if (pend_q[REQ_STOP]) begin
        state_d = G_SP_SDA_LO;
        kind_d  = 2'(REQ_STOP);
      end else if (pend_q[REQ_RESTART]) begin
        state_d = G_RS_SDA_REL;
        kind_d  = 2'(REQ_RESTART);
      end else if (pend_q[REQ_START]) begin
        state_d = G_ST_SDA_LO;
        kind_d  = 2'(REQ_START);
      end
    end else if (last) begin
      cnt_d = '0;
      unique case (state_q)
        G_RS_SDA_REL: state_d = G_RS_SCL_REL;
        G_RS_SCL_REL: state_d = G_ST_SDA_LO;
        G_ST_SDA_LO:  state_d = G_ST_SCL_LO;
        G_SP_SDA_LO:  state_d = G_SP_SCL_REL;
        G_SP_SCL_REL: state_d = G_SP_SDA_REL;
        default: begin
          state_d      = G_IDLE;
          done_d       = 1'b1;
          clr[kind_q]  = 1'b1;
        end
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (!en_i) begin
      state_d = G_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= G_IDLE;
      cnt_q   <= '0;
      kind_q  <= '0;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      done_q  <= done_d;
      pend_q  <= en_i ? ((pend_q & ~clr) | req_set_i) : '0;
    end
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      G_RS_SDA_REL: scl_oe_o = 1'b1;
      G_ST_SDA_LO:  sda_oe_o = 1'b1;
      G_ST_SCL_LO,
      G_SP_SDA_LO: begin
        scl_oe_o = 1'b1;
        sda_oe_o = 1'b1;
      end
      G_SP_SCL_REL: sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o = (state_q != G_IDLE);
  assign pend_o = pend_q;
  assign done_o = done_q;
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_mode_i,
  input  logic             shift_scl_oe_i,
  input  logic             shift_sda_oe_i,
  input  logic             sw_scl_oe_i,
  input  logic             sw_sda_oe_i,
  input  logic [REQ_W-1:0] req_set_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic [REQ_W-1:0] req_pend_o,
  output logic             start_det_o,
  output logic             stop_det_o,
  output logic             cond_irq_o
);
  logic [1:0] bus_s;
  logic       gen_busy, gen_scl_oe, gen_sda_oe, gen_done;

  i2c_cond_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  i2c_cond_detect u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (bus_s[1]),
    .sda_s_i     (bus_s[0]),
    .start_det_o (start_det_o),
    .stop_det_o  (stop_det_o)
  );

  i2c_cond_gen #(.HOLD_CYC(HOLD_CYC)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (gen_mode_i),
    .req_set_i (req_set_i),
    .pend_o    (req_pend_o),
    .busy_o    (gen_busy),
    .scl_oe_o  (gen_scl_oe),
    .sda_oe_o  (gen_sda_oe),
    .done_o    (gen_done)
  );

  always_comb begin
    if (!gen_mode_i) begin
      scl_oe_o = shift_scl_oe_i | sw_scl_oe_i;
      sda_oe_o = shift_sda_oe_i | sw_sda_oe_i;
    end else if (gen_busy) begin
      scl_oe_o = gen_scl_oe;
      sda_oe_o = gen_sda_oe;
    end else begin
      scl_oe_o = shift_scl_oe_i;
      sda_oe_o = shift_sda_oe_i;
    end
  end

  assign cond_irq_o = gen_mode_i ? gen_done : (start_det_o | stop_det_o);
endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gen_mode_i,
  input logic [2:0] req_pend_o,
  input logic       start_det_o,
  input logic       stop_det_o,
  input logic       cond_irq_o
);
  // R11
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_o |=> !start_det_o);

  // R11
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> !stop_det_o);

  // R11
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_mode_i && cond_irq_o) |=> !cond_irq_o);

  // R8
  det_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_det_o && stop_det_o));

  // R2, R12
  mode0_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_mode_i |=> (req_pend_o == 3'b000));

  // R7, R10
  clear_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gen_mode_i) && (($past(req_pend_o) & ~req_pend_o) != 3'b000))
      |-> (cond_irq_o && $countones($past(req_pend_o) & ~req_pend_o) == 1));
endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gen_mode_i  (gen_mode_i),
  .req_pend_o  (req_pend_o),
  .start_det_o (start_det_o),
  .stop_det_o  (stop_det_o),
  .cond_irq_o  (cond_irq_o)
);

// File: tb/tb_i2c_cond_ctrl.sv
module tb_i2c_cond_ctrl;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_mode = 1'b0;
  logic       sh_scl = 1'b0, sh_sda = 1'b0, sw_scl = 1'b0, sw_sda = 1'b0;
  logic       ext_scl = 1'b0, ext_sda = 1'b0;
  logic [2:0] req_set = 3'b000;
  logic       scl_bus, sda_bus, scl_oe, sda_oe, start_det, stop_det, cond_irq;
  logic [2:0] pend;

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_irq = 0;
  logic [1:0] exp_v [8];
  int         exp_l [8];
  logic [1:0] got_v [8];
  int         got_l [8];

  always #2.5 clk = ~clk;

  assign scl_bus = ~(scl_oe | ext_scl);
  assign sda_bus = ~(sda_oe | ext_sda);

  i2c_cond_ctrl #(.HOLD_CYC(H)) dut (
    .clk_i(clk), .rst_ni(rst_n), .gen_mode_i(gen_mode),
    .shift_scl_oe_i(sh_scl), .shift_sda_oe_i(sh_sda),
    .sw_scl_oe_i(sw_scl), .sw_sda_oe_i(sw_sda),
    .req_set_i(req_set), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .req_pend_o(pend),
    .start_det_o(start_det), .stop_det_o(stop_det), .cond_irq_o(cond_irq)
  );

  always @(negedge clk) begin
    if (start_det) n_start <= n_start + 1;
    if (stop_det)  n_stop  <= n_stop + 1;
    if (cond_irq)  n_irq   <= n_irq + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [2:0] m);
    @(negedge clk) req_set = m;
    @(negedge clk) req_set = 3'b000;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 100; i++) begin
      if (cond_irq) break;
      @(negedge clk);
    end
  endtask

  task automatic gen_case(input logic [2:0] m, input int n_exp, input string req);
    int n = 0;
    bit irq_seen = 0;
    pulse_req(m);
    for (int i = 0; i < 100; i++) begin
      if (cond_irq) begin irq_seen = 1; break; end
      if (n > 0 && got_v[n-1] == {scl_oe, sda_oe}) got_l[n-1]++;
      else if (n < 8) begin got_v[n] = {scl_oe, sda_oe}; got_l[n] = 1; n++; end
      @(negedge clk);
    end
    check(irq_seen, "R10", int'(irq_seen), 1);
    check(pend == 3'b000, req, int'(pend), 0);
    check(n == n_exp, req, n, n_exp);
    for (int k = 0; k < n_exp && k < n; k++) begin
      check(got_v[k] == exp_v[k], req, int'(got_v[k]), int'(exp_v[k]));
      check(got_l[k] == exp_l[k], req, got_l[k], exp_l[k]);
    end
    @(negedge clk);
    check(!cond_irq, "R11", int'(cond_irq), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(pend == 3'b000 && !scl_oe && !sda_oe, "R1", int'({pend, scl_oe, sda_oe}), 0);
    check(!start_det && !stop_det && !cond_irq, "R11", int'({start_det, stop_det, cond_irq}), 0);
  endtask

  task automatic t_mode0_mux();
    gen_mode = 1'b0;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      {sh_scl, sh_sda, sw_scl, sw_sda} = 4'(p);
      #1;
      check({scl_oe, sda_oe} == {sh_scl | sw_scl, sh_sda | sw_sda}, "R1",
            int'({scl_oe, sda_oe}), int'({sh_scl | sw_scl, sh_sda | sw_sda}));
    end
    @(negedge clk) {sh_scl, sh_sda, sw_scl, sw_sda} = 4'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_mode0_req_ignored();
    int irq0;
    gen_mode = 1'b0;
    irq0 = n_irq;
    pulse_req(3'b111);
    for (int i = 0; i < 3 * H; i++) begin
      @(negedge clk);
      check(pend == 3'b000 && !scl_oe && !sda_oe, "R2", int'({pend, scl_oe, sda_oe}), 0);
    end
    check(n_irq == irq0, "R2", n_irq - irq0, 0);
  endtask

  task automatic t_mode1_idle();
    @(negedge clk) gen_mode = 1'b1;
    sw_scl = 1'b1; sw_sda = 1'b1; sh_scl = 1'b0; sh_sda = 1'b1;
    #1 check({scl_oe, sda_oe} == 2'b01, "R3", int'({scl_oe, sda_oe}), 1);
    @(negedge clk) sw_scl = 1'b0; sw_sda = 1'b0; sh_sda = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_gen_start();
    int s0 = n_start;
    exp_v[0] = 2'b00; exp_l[0] = 1;
    exp_v[1] = 2'b01; exp_l[1] = H;
    exp_v[2] = 2'b11; exp_l[2] = H;
    gen_case(3'b001, 3, "R4");
    check(n_start - s0 == 1, "R8", n_start - s0, 1);
  endtask

  task automatic t_gen_restart();
    exp_v[0] = 2'b00; exp_l[0] = 1;
    exp_v[1] = 2'b10; exp_l[1] = H;
    exp_v[2] = 2'b00; exp_l[2] = H;
    exp_v[3] = 2'b01; exp_l[3] = H;
    exp_v[4] = 2'b11; exp_l[4] = H;
    gen_case(3'b010, 5, "R5");
  endtask

  task automatic t_gen_stop();
    int p0 = n_stop;
    exp_v[0] = 2'b00; exp_l[0] = 1;
    exp_v[1] = 2'b11; exp_l[1] = H;
    exp_v[2] = 2'b01; exp_l[2] = H;
    exp_v[3] = 2'b00; exp_l[3] = H;
    gen_case(3'b100, 4, "R6");
    repeat (4) @(negedge clk);
    check(n_stop - p0 == 1, "R8", n_stop - p0, 1);
  endtask

  task automatic t_priority();
    pulse_req(3'b111);
    check(pend == 3'b111, "R7", int'(pend), 7);
    @(negedge clk);
    check(scl_oe && sda_oe, "R7", int'({scl_oe, sda_oe}), 3);
    wait_irq();
    check(pend == 3'b011, "R7", int'(pend), 3);
    @(negedge clk);
    check(scl_oe && !sda_oe, "R7", int'({scl_oe, sda_oe}), 2);
    wait_irq();
    check(pend == 3'b001, "R7", int'(pend), 1);
    @(negedge clk);
    wait_irq();
    check(pend == 3'b000, "R7", int'(pend), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_detect_mode0();
    int s0, p0, i0;
    gen_mode = 1'b0;
    repeat (6) @(negedge clk);
    s0 = n_start; p0 = n_stop; i0 = n_irq;
    sw_sda = 1'b1;
    repeat (6) @(negedge clk);
    check(n_start - s0 == 1 && n_stop == p0, "R8", n_start - s0, 1);
    check(n_irq - i0 == 1, "R9", n_irq - i0, 1);
    sw_sda = 1'b0;
    repeat (6) @(negedge clk);
    check(n_stop - p0 == 1, "R8", n_stop - p0, 1);
    check(n_irq - i0 == 2, "R9", n_irq - i0, 2);
    sw_scl = 1'b1;
    repeat (4) @(negedge clk);
    sw_sda = 1'b1;
    repeat (4) @(negedge clk);
    sw_sda = 1'b0;
    repeat (4) @(negedge clk);
    sw_scl = 1'b0;
    repeat (6) @(negedge clk);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R8", n_start - s0 + n_stop - p0, 2);
  endtask

  task automatic t_detect_mode1();
    int s0, p0, i0;
    @(negedge clk) gen_mode = 1'b1;
    repeat (4) @(negedge clk);
    s0 = n_start; p0 = n_stop; i0 = n_irq;
    ext_sda = 1'b1;
    repeat (6) @(negedge clk);
    ext_sda = 1'b0;
    repeat (6) @(negedge clk);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R8", n_start - s0 + n_stop - p0, 2);
    check(n_irq == i0, "R10", n_irq - i0, 0);
  endtask

  task automatic t_abort();
    gen_mode = 1'b1;
    pulse_req(3'b101);
    repeat (H) @(negedge clk);
    gen_mode = 1'b0;
    #1 check(!scl_oe && !sda_oe, "R12", int'({scl_oe, sda_oe}), 0);
    @(negedge clk);
    check(pend == 3'b000, "R12", int'(pend), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode0_mux();
    t_mode0_req_ignored();
    t_mode1_idle();
    t_gen_start();
    t_gen_restart();
    t_gen_stop();
    t_priority();
    t_detect_mode1();
    t_detect_mode0();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule